// File: doc/BRIEF.md
# Multiprocessor Interrupt Level Controller

This block collects interrupt requests for a four-processor system and turns them into one 4-bit priority level per processor (1 is the lowest, 15 the highest, 0 means idle). Each processor has a private register of software interrupt bits, one per level, plus a private tick input that is always delivered at level 14. A shared set of device and error lines passes through a global mask register. Device lines are steered to the single processor named by a target register. Error lines go to every processor.

Software uses a small 32-bit register bus to raise and drop software interrupts, to mask and unmask shared sources, and to choose the target processor. Every change goes through a pair of write-one ports, one that sets and one that clears. Bits written as 0 keep their value, so separate agents can update one bit without a read-modify-write sequence. The level outputs are registered, so they change one cycle after the request lines or the registers change.

Top module: `mp_irq_level_ctrl`

## Requirements
- R1: After reset, every global mask bit is 1 (all 32 bits), the target register is 0, every software bit is 0, and every level output is 0.
- R2: Processor c's registers sit at byte address c*0x20. A write to offset 0x8 sets software bits 31:17, and a write to offset 0x4 clears them. Each 1 in the write data acts on its bit. A 0 leaves the bit alone. Bits 16:0 of the write data are ignored. Offsets 0x0, 0x4 and 0x8 all read the processor's pending word.
- R3: The global page is at byte address 0x80. Writing to 0x8C sets mask bits and writing to 0x88 clears them, again one bit per 1 in the write data. Offsets 0x84, 0x88 and 0x8C read the mask. Offset 0x80 reads the shared request lines, with unassigned bits (31 and 26:23) shown as 0.
- R4: Software bit 16+n of processor c, for n from 1 to 15, requests level n on processor c only.
- R5: The tick input of processor c requests level 14 on processor c only and reads back as bit 7 of that processor's pending word.
- R6: Shared device lines map to levels as follows: bit 18→4, 16→6, 20→8, 21→9, 19→10, 22→11, 14 and 15→12, 17→13. Line pairs 0–6 and 7–13 each represent bus levels k=1..7, which map to 2,3,5,7,9,11,13. A device line requests only on the target processor.
- R7: Shared lines 30:27 are error sources at level 15 and are delivered to every processor.
- R8: A shared line is delivered only while its own mask bit is 0 and global mask bit 31 is 0. Bit 31 blocks every shared line, errors included.
- R9: A write to 0x90 loads the target register from the low log2(4) bits of the write data. A read of 0x90 returns it zero-extended.
- R10: Each processor's level is the highest level among all of its active requests, and 0 when it has none.
- R11: Shared lines and tick inputs are level-sensitive and are never latched. A request disappears as soon as its line drops.
- R12: A level output reflects the line and register values sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rb_we | input | 1 | Register write strobe |
| rb_addr | input | 8 | Register byte address |
| rb_wdata | input | 32 | Write data |
| rb_rdata | output | 32 | Read data for rb_addr (combinational) |
| dev_irq_i | input | 32 | Shared device and error request lines |
| cpu_tick_i | input | 4 | Per-processor tick request lines |
| cpu_level_o | output | 16 | Four 4-bit levels, processor c in bits 4c+3:4c |

## Verification
The assertions check on every cycle a few properties that hold no matter which sources are active. Written mask bits take effect. An unmasked error forces level 15 on all processors. A set global-off bit with no soft or tick requests gives zero levels. A tick never yields a level below 14. Other behaviour depends on particular combinations of requests, and only the bench's scenarios can show it. That includes the exact level of each shared line, steering to the target processor only, the outcome when software and tick requests compete, write-zero immunity, and the register read views. The bench covers these by walking each shared bit one at a time and comparing every processor's level against a behavioural model on every cycle.

// File: rtl/irqc_pkg.sv
// Shared constants and source-to-level map for the interrupt level controller.
// Assumes a 32-bit register bus and 4-bit priority levels.
package irqc_pkg;

    localparam int LVL_W   = 4;
    localparam int OFF_W   = 5;

    // Register offsets within a page.
    localparam logic [OFF_W-1:0] OFF_PEND  = 5'h00;
    localparam logic [OFF_W-1:0] OFF_CCLR  = 5'h04;
    localparam logic [OFF_W-1:0] OFF_CSET  = 5'h08;
    localparam logic [OFF_W-1:0] OFF_MASK  = 5'h04;
    localparam logic [OFF_W-1:0] OFF_MCLR  = 5'h08;
    localparam logic [OFF_W-1:0] OFF_MSET  = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_TGT   = 5'h10;

    localparam int MASK_ALL_BIT = 31;
    localparam logic [LVL_W-1:0] ERR_LVL  = 4'd15;
    localparam logic [LVL_W-1:0] TICK_LVL = 4'd14;

    // Level for bus request k (1..7): 2 for k=1, otherwise 2k-1.
    function automatic logic [LVL_W-1:0] bus_lvl(input int unsigned k);
        return (k == 1) ? 4'd2 : LVL_W'(2 * k - 1);
    endfunction

    // Level for shared line b, or 0 when the line is unassigned.
    function automatic logic [LVL_W-1:0] src_level(input int unsigned b);
        if (b <= 6)  return bus_lvl(b + 1);
        if (b <= 13) return bus_lvl(b - 6);
        case (b)
            14, 15:         return 4'd12;
            16:             return 4'd6;
            17:             return 4'd13;
            18:             return 4'd4;
            19:             return 4'd10;
            20:             return 4'd8;
            21:             return 4'd9;
            22:             return 4'd11;
            27, 28, 29, 30: return ERR_LVL;
            default:        return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/irqc_cpu_regs.sv
// Per-processor software interrupt register with write-one set/clear ports.
// Also forms the pending read word and this processor's private level vector.
// Assumes set and clear strobes are never active together (distinct addresses).
module irqc_cpu_regs
    import irqc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_we,
    input  logic        clr_we,
    input  logic [15:1] wbits,
    input  logic        tick_i,
    output logic [31:0] pend_o,
    output logic [15:1] lvl_vec_o
);

    logic [15:1] soft_q;

    // Software bits: set and clear by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)      soft_q <= '0;
        else if (set_we) soft_q <= soft_q | wbits;
        else if (clr_we) soft_q <= soft_q & ~wbits;
    end

    // Read view: soft bits at 31:17, tick at bit 7.
    always_comb begin
        pend_o = {soft_q, 1'b0, 8'h00, tick_i, 7'h00};
    end

    // Private requests: soft level n at index n, tick at level 14.
    always_comb begin
        lvl_vec_o = soft_q;
        if (tick_i) lvl_vec_o[TICK_LVL] = 1'b1;
    end

endmodule

// File: rtl/irqc_global_regs.sv
// Global mask register (write-one set/clear) and the target-processor register.
// Assumes NCPU is a power of two of at least 2.
module irqc_global_regs #(
    parameter int NCPU  = 4,
    localparam int CPU_W = $clog2(NCPU)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mset_we,
    input  logic             mclr_we,
    input  logic             tgt_we,
    input  logic [31:0]      wdata,
    output logic [31:0]      mask_o,
    output logic [CPU_W-1:0] tgt_o
);

    // Mask: all sources blocked from reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_o <= '1;
        else if (mset_we) mask_o <= mask_o | wdata;
        else if (mclr_we) mask_o <= mask_o & ~wdata;
    end

    // Target processor for device lines.
    always_ff @(posedge clk) begin
        if (!rst_n)      tgt_o <= '0;
        else if (tgt_we) tgt_o <= wdata[CPU_W-1:0];
    end

endmodule

// File: rtl/irqc_route.sv
// Turns shared request lines into two level vectors: one steered to the target
// processor and one broadcast to all processors. Assumes level-sensitive lines.
module irqc_route
    import irqc_pkg::*;
(
    input  logic [31:0] src_i,
    input  logic [31:0] mask_i,
    output logic [15:1] routed_o,
    output logic [15:1] bcast_o
);

    logic [LVL_W-1:0] lv;

    // OR the one-hot level of every live line into its vector.
    always_comb begin
        routed_o = '0;
        bcast_o  = '0;
        lv       = '0;
        for (int b = 0; b < 32; b++) begin
            lv = src_level(b);
            if (src_i[b] && !mask_i[b] && !mask_i[MASK_ALL_BIT] && lv != 4'd0) begin
                if (lv == ERR_LVL) bcast_o[15] = 1'b1;
                else               routed_o[lv] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqc_lvl_enc.sv
// Priority encoder: returns the index of the highest set bit, 0 when none.
module irqc_lvl_enc
    import irqc_pkg::*;
(
    input  logic [15:1]      vec_i,
    output logic [LVL_W-1:0] lvl_o
);

    // Scan upward so the highest set index wins.
    always_comb begin
        lvl_o = '0;
        for (int i = 1; i < 16; i++) begin
            if (vec_i[i]) lvl_o = LVL_W'(i);
        end
    end

endmodule

// File: rtl/mp_irq_level_ctrl.sv
// Interrupt mask and level controller for NCPU processors.
// Page c (c < NCPU) holds processor c's registers; page NCPU holds the global
// mask, shared pending and target. Each level output is registered.
// Assumes pages of 32 bytes and an address wide enough for NCPU+1 pages.
module mp_irq_level_ctrl
    import irqc_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 8,
    localparam int CPU_W = $clog2(NCPU),
    localparam int PG_W  = ADDR_W - OFF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rb_we,
    input  logic [ADDR_W-1:0]     rb_addr,
    input  logic [31:0]           rb_wdata,
    output logic [31:0]           rb_rdata,
    input  logic [31:0]           dev_irq_i,
    input  logic [NCPU-1:0]       cpu_tick_i,
    output logic [NCPU*LVL_W-1:0] cpu_level_o
);

    localparam logic [PG_W-1:0] GPAGE = PG_W'(NCPU);
    localparam logic [31:0] IMPL_BITS = 32'h787F_FFFF;

    logic [PG_W-1:0]  page;
    logic [OFF_W-1:0] off;
    logic             g_sel;
    logic [31:0]      mask_q;
    logic [CPU_W-1:0] tgt_q;
    logic [15:1]      routed_vec;
    logic [15:1]      bcast_vec;
    logic [31:0]      cpu_pend [NCPU];
    logic [NCPU*32-1:0] pend_flat;
    logic [LVL_W-1:0] lvl_next [NCPU];

    assign page  = rb_addr[ADDR_W-1:OFF_W];
    assign off   = rb_addr[OFF_W-1:0];
    assign g_sel = (page == GPAGE);

    irqc_global_regs #(.NCPU(NCPU)) u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .mset_we (rb_we && g_sel && off == OFF_MSET),
        .mclr_we (rb_we && g_sel && off == OFF_MCLR),
        .tgt_we  (rb_we && g_sel && off == OFF_TGT),
        .wdata   (rb_wdata),
        .mask_o  (mask_q),
        .tgt_o   (tgt_q)
    );

    irqc_route u_route (
        .src_i    (dev_irq_i),
        .mask_i   (mask_q),
        .routed_o (routed_vec),
        .bcast_o  (bcast_vec)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        localparam logic [PG_W-1:0]  MY_PG  = PG_W'(c);
        localparam logic [CPU_W-1:0] MY_ID  = CPU_W'(c);
        logic [15:1] own_vec;
        logic [15:1] all_vec;

        irqc_cpu_regs u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_we    (rb_we && page == MY_PG && off == OFF_CSET),
            .clr_we    (rb_we && page == MY_PG && off == OFF_CCLR),
            .wbits     (rb_wdata[31:17]),
            .tick_i    (cpu_tick_i[c]),
            .pend_o    (cpu_pend[c]),
            .lvl_vec_o (own_vec)
        );

        // Merge private, broadcast and (if targeted) steered requests.
        always_comb begin
            all_vec = own_vec | bcast_vec | ((tgt_q == MY_ID) ? routed_vec : 15'h0);
        end

        irqc_lvl_enc u_enc (
            .vec_i (all_vec),
            .lvl_o (lvl_next[c])
        );

        // Registered level output for this processor.
        always_ff @(posedge clk) begin
            if (!rst_n) cpu_level_o[c*LVL_W +: LVL_W] <= '0;
            else        cpu_level_o[c*LVL_W +: LVL_W] <= lvl_next[c];
        end

        assign pend_flat[c*32 +: 32] = cpu_pend[c];
    end

    // Register read multiplexer.
    always_comb begin
        rb_rdata = '0;
        if (page < GPAGE) begin
            if (off == OFF_PEND || off == OFF_CCLR || off == OFF_CSET)
                rb_rdata = cpu_pend[page[CPU_W-1:0]];
        end else if (g_sel) begin
            case (off)
                OFF_PEND:                     rb_rdata = dev_irq_i & IMPL_BITS;
                OFF_MASK, OFF_MCLR, OFF_MSET: rb_rdata = mask_q;
                OFF_TGT:                      rb_rdata = 32'(tgt_q);
                default:                      rb_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqc_chk.sv
// Assertion checker for mp_irq_level_ctrl, attached by bind below.
module irqc_chk #(
    parameter int NCPU   = 4,
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rb_we,
    input logic [ADDR_W-1:0]   rb_addr,
    input logic [31:0]         rb_wdata,
    input logic [31:0]         dev_irq_i,
    input logic [NCPU-1:0]     cpu_tick_i,
    input logic [NCPU*4-1:0]   cpu_level_o,
    input logic [31:0]         mask_q,
    input logic [NCPU*32-1:0]  pend_flat
);

    localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(NCPU * 32 + 12);
    localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(NCPU * 32 + 8);

    logic soft_any;
    logic err_live;

    // Any software bit pending on any processor.
    always_comb begin
        soft_any = 1'b0;
        for (int c = 0; c < NCPU; c++) soft_any = soft_any | (|pend_flat[c*32+17 +: 15]);
    end

    assign err_live = !mask_q[31] && (|(dev_irq_i[30:27] & ~mask_q[30:27]));

    a_r1_zero_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> cpu_level_o == '0);

    a_r3_mask_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_we && rb_addr == A_MSET) |=> ((mask_q & $past(rb_wdata)) == $past(rb_wdata)));

    a_r3_mask_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_we && rb_addr == A_MCLR) |=> ((mask_q & $past(rb_wdata)) == 32'h0));

    a_r7_error_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        err_live |=> cpu_level_o == {NCPU{4'hF}});

    a_r8_global_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q[31] && cpu_tick_i == '0 && !soft_any) |=> cpu_level_o == '0);

    for (genvar c = 0; c < NCPU; c++) begin : g_tick
        a_r5_tick_floor: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_tick_i[c] |=> cpu_level_o[c*4 +: 4] >= 4'd14);
    end

endmodule

bind mp_irq_level_ctrl irqc_chk #(.NCPU(NCPU), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rb_we       (rb_we),
    .rb_addr     (rb_addr),
    .rb_wdata    (rb_wdata),
    .dev_irq_i   (dev_irq_i),
    .cpu_tick_i  (cpu_tick_i),
    .cpu_level_o (cpu_level_o),
    .mask_q      (mask_q),
    .pend_flat   (pend_flat)
);

// File: tb/mp_irq_level_ctrl_bench.sv
// Bench: behavioural reference model compared against every level on every clock,
// plus register read-back checks.
module mp_irq_level_ctrl_bench;

    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rb_we = 1'b0;
    logic [7:0]  rb_addr = '0;
    logic [31:0] rb_wdata = '0;
    logic [31:0] rb_rdata;
    logic [31:0] dev_irq_i = '0;
    logic [NCPU-1:0] cpu_tick_i = '0;
    logic [NCPU*4-1:0] cpu_level_o;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // Model state.
    logic [31:0] m_soft [NCPU];
    logic [31:0] m_mask;
    int          m_tgt;
    int          m_exp  [NCPU];

    always #10 clk = ~clk;

    mp_irq_level_ctrl u_mp_irq_level_ctrl (
        .clk(clk), .rst_n(rst_n), .rb_we(rb_we), .rb_addr(rb_addr),
        .rb_wdata(rb_wdata), .rb_rdata(rb_rdata), .dev_irq_i(dev_irq_i),
        .cpu_tick_i(cpu_tick_i), .cpu_level_o(cpu_level_o)
    );

    function automatic int line_level(int b);
        case (b)
            0, 7:  return 2;   1, 8:  return 3;   2, 9:  return 5;
            3, 10: return 7;   4, 11: return 9;   5, 12: return 11;
            6, 13: return 13;  14, 15: return 12; 16: return 6;
            17: return 13;     18: return 4;      19: return 10;
            20: return 8;      21: return 9;      22: return 11;
            27, 28, 29, 30: return 15;
            default: return 0;
        endcase
    endfunction

    // Reference model: expected levels from pre-edge state, then register writes.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCPU; c++) begin m_soft[c] = '0; m_exp[c] = 0; end
            m_mask = '1;
            m_tgt  = 0;
        end else begin
            for (int c = 0; c < NCPU; c++) begin
                int best;
                best = 0;
                for (int n = 1; n < 16; n++) if (m_soft[c][16+n]) best = n;
                if (cpu_tick_i[c] && best < 14) best = 14;
                for (int b = 0; b < 32; b++) begin
                    int l;
                    l = line_level(b);
                    if (dev_irq_i[b] && !m_mask[b] && !m_mask[31] && l != 0 &&
                        (l == 15 || c == m_tgt) && l > best) best = l;
                end
                m_exp[c] = best;
            end
            if (rb_we) begin
                for (int c = 0; c < NCPU; c++) begin
                    if (rb_addr == 8'(c*32 + 4)) m_soft[c] = m_soft[c] & ~(rb_wdata & 32'hFFFE_0000);
                    if (rb_addr == 8'(c*32 + 8)) m_soft[c] = m_soft[c] | (rb_wdata & 32'hFFFE_0000);
                end
                if (rb_addr == 8'h88) m_mask = m_mask & ~rb_wdata;
                if (rb_addr == 8'h8C) m_mask = m_mask | rb_wdata;
                if (rb_addr == 8'h90) m_tgt  = int'(rb_wdata[1:0]);
            end
        end
    end

    // One clock, then compare every processor's level against the model.
    task automatic cyc();
        @(posedge clk);
        #5;
        for (int c = 0; c < NCPU; c++) begin
            checks++;
            if (int'(cpu_level_o[c*4 +: 4]) != m_exp[c]) begin
                fails++;
                $display("FAIL %s (R12 timing) cpu%0d level actual=%0d expected=%0d",
                         cur_req, c, cpu_level_o[c*4 +: 4], m_exp[c]);
            end
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        rb_we = 1'b1; rb_addr = a; rb_wdata = d;
        cyc();
        rb_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rb_addr = a;
        #1;
        checks++;
        if (rb_rdata !== exp) begin
            fails++;
            $display("FAIL %s read 0x%02h actual=0x%08h expected=0x%08h", tag, a, rb_rdata, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        rd(8'h84, 32'hFFFF_FFFF, "R1 mask");
        rd(8'h90, 32'h0, "R1 target");
        rd(8'h20, 32'h0, "R1 soft");

        // R2/R4: software set/clear, write-zero immunity, low bits ignored
        cur_req = "R2";
        wr(8'h28, 32'h0020_0008);
        cyc();
        rd(8'h20, 32'h0020_0000, "R2 set");
        rd(8'h24, 32'h0020_0000, "R2 clr-port view");
        cur_req = "R4";
        wr(8'h28, 32'h0200_0000);
        cyc();
        cur_req = "R10";
        wr(8'h24, 32'h0200_0000);
        cyc();
        cur_req = "R2";
        wr(8'h24, 32'h0000_0000);
        cyc();
        rd(8'h20, 32'h0020_0000, "R2 zero-write");
        wr(8'h68, 32'hFFFE_0000);
        cyc();
        rd(8'h60, 32'hFFFE_0000, "R2 all soft");
        wr(8'h64, ~32'h0001_7FFF);
        wr(8'h24, ~32'h0001_7FFF);
        cyc();
        rd(8'h60, 32'h0, "R2 bulk clear");

        // R5: tick on processor 2
        cur_req = "R5";
        cpu_tick_i = 4'b0100;
        cyc(); cyc();
        rd(8'h40, 32'h0000_0080, "R5 tick bit");
        cpu_tick_i = '0;
        cyc();

        // R3/R8: masked device line, then unmask
        cur_req = "R8";
        dev_irq_i = 32'h0004_0000;
        cyc(); cyc();
        rd(8'h80, 32'h0004_0000, "R3 pending");
        cur_req = "R3";
        wr(8'h88, 32'h0004_0000);
        cyc();
        rd(8'h84, 32'hFFFB_FFFF, "R3 mask clr");
        cur_req = "R8";
        wr(8'h88, 32'h8000_0000);
        cyc();
        rd(8'h8C, 32'h7FFB_FFFF, "R8 mask view");

        // R9: steer to processor 3
        cur_req = "R9";
        wr(8'h90, 32'hFFFF_FFF3);
        cyc();
        rd(8'h90, 32'h3, "R9 target");
        wr(8'h90, 32'h0);

        // R6/R7: walk every shared line with all sources unmasked
        cur_req = "R6";
        wr(8'h88, 32'hFFFF_FFFF);
        for (int b = 0; b < 32; b++) begin
            dev_irq_i = 32'h1 << b;
            cur_req = (b >= 27 && b <= 30) ? "R7" : "R6";
            cyc(); cyc();
        end
        dev_irq_i = 32'hA000_0000;
        cyc();
        rd(8'h80, 32'h2000_0000, "R3 unassigned read 0");

        // R10: competing requests on target 1
        cur_req = "R10";
        wr(8'h90, 32'h1);
        dev_irq_i = 32'h0002_0001;
        wr(8'h28, 32'h0040_0000);
        cpu_tick_i = 4'b0010;
        cyc(); cyc();
        cpu_tick_i = '0;
        cyc(); cyc();

        // R11: lines drop, levels follow
        cur_req = "R11";
        dev_irq_i = '0;
        cyc(); cyc();
        dev_irq_i = 32'h1000_0000;
        cyc();
        dev_irq_i = '0;
        cyc(); cyc();

        // R8: mask-all blocks errors
        cur_req = "R8";
        wr(8'h8C, 32'h8000_0000);
        dev_irq_i = 32'h7800_0000;
        cyc(); cyc();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule